// File: doc/BRIEF.md
# Relaxed-Order Memory Interval Recorder

This block watches the memory accesses of one processor core and turns them into a compact log of intervals for deterministic replay. An interval is the stretch of work between two external communications. Here, each snooped coherence transaction that reaches the core ends the current interval, and the next interval starts at once. Accesses are retired into an interval by counting events, which arrive in program order. Perform events can arrive in any order. Each perform event carries the access's sequence tag and its cache-line address.

An access whose perform and count both fall in one interval is treated as if it performed at its counting point, so it shows up only in the interval's count. An access that performed in an earlier interval may also be folded into the count, in one of two ways. In base mode it never is: such an access is always recorded as an exception. In optimized mode it is folded unless a snooped transaction to its line arrived between its perform and its count. Each closed, non-empty interval yields one log entry. The entry holds the number of accesses counted and up to a fixed number of exception records, each giving the position of a reordered access within the interval.

The counting input and the log output are both valid/ready. A log entry stays on the output until the consumer takes it. While an entry is waiting, counting is held off, so the interval behind it stays empty. A count is also held off until the perform event for that access has been seen.

Top module: `mem_interval_recorder`

## Requirements
- R1: After reset, `log_valid` is 0 and `cnt_ready` is 0, the tracking table is empty and the first interval starts with a count of zero.
- R2: `cnt_ready` stays 0 until the perform pulse for the next access in program order has been registered. The cycle after that perform pulse, `cnt_ready` rises (given no other stall). Counts consume sequence tags in increasing order, modulo DEPTH.
- R3: Accesses whose perform and count fall in the same interval appear only in the count, whatever the order of their perform pulses (`log_nexc` = 0).
- R4: A `snoop_valid` pulse closes the interval. A count accepted in the same cycle belongs to the closing interval. The entry appears on `log_valid` the next cycle. An interval with zero counted accesses produces no entry.
- R5: In base mode (`opt_mode` = 0), every access counted in a later interval than the one it performed in is recorded as an exception.
- R6: In optimized mode (`opt_mode` = 1), such an access is recorded as an exception only if a snoop with an equal line address arrived after its perform pulse and before its count. Otherwise it is folded into the count.
- R7: `log_count` is the number of accesses counted in the interval. `log_nexc` is the number of exceptions. Exception slot k occupies `log_exc[k*CNTW +: CNTW]` and holds the 0-based program-order offset of the access within the interval. Slots fill from k = 0 upward, and unused slots read 0.
- R8: While `log_valid` = 1 and `log_ready` = 0, the log fields hold steady and `cnt_ready` = 0. A snoop during this stall adds no entry, but still marks line conflicts. The entry leaves on the first cycle with `log_ready` = 1.
- R9: When MAXEXC exceptions are already held and the next access to count is another exception, the block closes the interval by itself instead of counting. That access is then counted at offset 0 of the new interval.
- R10: When the interval's count has reached 2^CNTW-1, the next ready count instead closes the interval by itself. The access is counted in the new interval.
- R11: A perform pulse in the same cycle as a snoop belongs to the new interval, and that snoop does not mark it as conflicting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opt_mode | input | 1 | 0 = base mode, 1 = optimized mode |
| perf_valid | input | 1 | Perform pulse |
| perf_seq | input | $clog2(DEPTH) | Sequence tag (mod DEPTH) of the performing access |
| perf_line | input | LINEW | Line address of the performing access |
| cnt_valid | input | 1 | Next access in program order is being counted |
| cnt_ready | output | 1 | Count accepted this cycle when high with `cnt_valid` |
| snoop_valid | input | 1 | Incoming coherence transaction; closes the interval |
| snoop_line | input | LINEW | Line address of the snooped transaction |
| log_valid | output | 1 | Log entry available |
| log_ready | input | 1 | Consumer takes the log entry |
| log_count | output | CNTW | Accesses counted in the interval |
| log_nexc | output | $clog2(MAXEXC+1) | Number of exception records in use |
| log_exc | output | MAXEXC*CNTW | Exception offsets, slot k at bits k*CNTW upward |

## Verification
The bench builds the block with DEPTH = 8, LINEW = 8, CNTW = 3 and MAXEXC = 4. The 3-bit count field saturates after seven accesses, so the self-close on a full count (R10) is reached in a short run. The 8-entry table holds five accesses in flight, enough to reach the fifth exception and the self-close on a full exception list (R9). The 8-bit line addresses make line matches and mismatches easy to choose, which lets the bench tell the two modes apart.

// File: rtl/mir_pkg.sv
package mir_pkg;

  // An access that crossed an interval boundary must be recorded as an
  // exception: always in base mode, only when a line conflict was seen in
  // optimized mode.
  function automatic logic must_record(logic crossed, logic conflict, logic opt);
    return crossed & (~opt | conflict);
  endfunction

endpackage

// File: rtl/mir_track_table.sv
module mir_track_table #(
  parameter int DEPTH = 16,
  parameter int LINEW = 26,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            perf_valid,
  input  logic [IDXW-1:0] perf_idx,
  input  logic [LINEW-1:0] perf_line,
  input  logic            snoop_valid,
  input  logic [LINEW-1:0] snoop_line,
  input  logic            close_iv,
  input  logic [IDXW-1:0] head_idx,
  input  logic            clr,
  output logic            head_perf,
  output logic            head_crossed,
  output logic            head_conflict
);

  logic [DEPTH-1:0] valid_q, crossed_q, conf_q;
  logic [LINEW-1:0] line_q [DEPTH];
  logic [DEPTH-1:0] sel_perf, sel_clr, snoop_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign sel_perf[i]  = perf_valid && (perf_idx == IDXW'(i));
    assign sel_clr[i]   = clr && (head_idx == IDXW'(i));
    assign snoop_hit[i] = snoop_valid && valid_q[i] && (line_q[i] == snoop_line);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= '0;
      crossed_q <= '0;
      conf_q    <= '0;
      for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (sel_clr[i]) begin
          valid_q[i] <= 1'b0;
        end else if (sel_perf[i]) begin
          valid_q[i]   <= 1'b1;
          crossed_q[i] <= 1'b0;
          conf_q[i]    <= 1'b0;
          line_q[i]    <= perf_line;
        end else if (valid_q[i]) begin
          if (close_iv)     crossed_q[i] <= 1'b1;
          if (snoop_hit[i]) conf_q[i]    <= 1'b1;
        end
      end
    end
  end

  assign head_perf     = valid_q[head_idx];
  assign head_crossed  = crossed_q[head_idx];
  assign head_conflict = conf_q[head_idx];

  // R2: a count only retires an entry that has performed
  a_r2_clear_performed: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> valid_q[head_idx]);
  // R2: a perform never lands on an entry still in flight
  a_r2_no_double_perform: assert property (@(posedge clk) disable iff (!rst_n)
    perf_valid |-> !valid_q[perf_idx]);
  // R6: a conflict is only ever seen together with an interval crossing
  a_r6_conflict_implies_crossed: assert property (@(posedge clk) disable iff (!rst_n)
    (conf_q & ~crossed_q & valid_q) == '0);

endmodule

// File: rtl/mir_interval_acc.sv
module mir_interval_acc #(
  parameter int DEPTH  = 16,
  parameter int CNTW   = 8,
  parameter int MAXEXC = 4,
  localparam int IDXW  = $clog2(DEPTH),
  localparam int EXCW  = $clog2(MAXEXC + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cnt_valid,
  input  logic                   head_perf,
  input  logic                   head_exc,
  input  logic                   snoop_valid,
  input  logic                   log_free,
  output logic                   cnt_ready,
  output logic                   cnt_fire,
  output logic                   close_iv,
  output logic                   log_load,
  output logic [IDXW-1:0]        head_idx,
  output logic [CNTW-1:0]        ld_count,
  output logic [EXCW-1:0]        ld_nexc,
  output logic [MAXEXC*CNTW-1:0] ld_exc
);

  localparam logic [CNTW-1:0] CNT_MAX = '1;

  logic [IDXW-1:0]                head_q;
  logic [CNTW-1:0]                cnt_q, cnt_nx;
  logic [EXCW-1:0]                nexc_q, nexc_nx;
  logic [MAXEXC-1:0][CNTW-1:0]    exc_q, exc_nx;
  logic                           full, self_close, rec;

  assign full       = (cnt_q == CNT_MAX) || (head_exc && nexc_q == EXCW'(MAXEXC));
  assign cnt_ready  = head_perf && log_free && !full;
  assign cnt_fire   = cnt_valid && cnt_ready;
  assign self_close = cnt_valid && head_perf && log_free && full;
  assign close_iv   = snoop_valid || self_close;
  assign rec        = cnt_fire && head_exc;

  always_comb begin
    cnt_nx  = cnt_q + CNTW'(cnt_fire);
    nexc_nx = nexc_q + EXCW'(rec);
    exc_nx  = exc_q;
    for (int k = 0; k < MAXEXC; k++)
      if (rec && nexc_q == EXCW'(k)) exc_nx[k] = cnt_q;
  end

  assign log_load = close_iv && (cnt_nx != '0);
  assign ld_count = cnt_nx;
  assign ld_nexc  = nexc_nx;
  assign ld_exc   = exc_nx;
  assign head_idx = head_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
      nexc_q <= '0;
      exc_q  <= '0;
    end else begin
      if (cnt_fire) head_q <= head_q + 1'b1;
      if (close_iv) begin
        cnt_q  <= '0;
        nexc_q <= '0;
        exc_q  <= '0;
      end else begin
        cnt_q  <= cnt_nx;
        nexc_q <= nexc_nx;
        exc_q  <= exc_nx;
      end
    end
  end

  // R8: no access is counted while the log output is blocked
  a_r8_idle_while_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    !log_free |-> cnt_q == '0);
  // R9: the exception list never exceeds its capacity
  a_r9_exc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    nexc_q <= EXCW'(MAXEXC));
  // R4: an entry is only loaded when the output can take it
  a_r4_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    log_load |-> log_free);

endmodule

// File: rtl/mir_log_reg.sv
module mir_log_reg #(
  parameter int CNTW   = 8,
  parameter int MAXEXC = 4,
  localparam int EXCW  = $clog2(MAXEXC + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [CNTW-1:0]        in_count,
  input  logic [EXCW-1:0]        in_nexc,
  input  logic [MAXEXC*CNTW-1:0] in_exc,
  input  logic                   log_ready,
  output logic                   log_valid,
  output logic                   log_free,
  output logic [CNTW-1:0]        log_count,
  output logic [EXCW-1:0]        log_nexc,
  output logic [MAXEXC*CNTW-1:0] log_exc
);

  assign log_free = !log_valid || log_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log_valid <= 1'b0;
      log_count <= '0;
      log_nexc  <= '0;
      log_exc   <= '0;
    end else if (load) begin
      log_valid <= 1'b1;
      log_count <= in_count;
      log_nexc  <= in_nexc;
      log_exc   <= in_exc;
    end else if (log_ready) begin
      log_valid <= 1'b0;
    end
  end

  // R8: a waiting entry holds steady until taken
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_ready) |=> (log_valid && $stable(log_count)
                                   && $stable(log_nexc) && $stable(log_exc)));
  // R4: a presented entry is never empty
  a_r4_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> log_count != '0);

endmodule

// File: rtl/mem_interval_recorder.sv
module mem_interval_recorder #(
  parameter int DEPTH  = 16,
  parameter int LINEW  = 26,
  parameter int CNTW   = 8,
  parameter int MAXEXC = 4,
  localparam int IDXW  = $clog2(DEPTH),
  localparam int EXCW  = $clog2(MAXEXC + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   opt_mode,
  input  logic                   perf_valid,
  input  logic [IDXW-1:0]        perf_seq,
  input  logic [LINEW-1:0]       perf_line,
  input  logic                   cnt_valid,
  output logic                   cnt_ready,
  input  logic                   snoop_valid,
  input  logic [LINEW-1:0]       snoop_line,
  output logic                   log_valid,
  input  logic                   log_ready,
  output logic [CNTW-1:0]        log_count,
  output logic [EXCW-1:0]        log_nexc,
  output logic [MAXEXC*CNTW-1:0] log_exc
);

  logic                   head_perf, head_crossed, head_conflict, head_exc;
  logic                   cnt_fire, close_iv, log_load, log_free;
  logic [IDXW-1:0]        head_idx;
  logic [CNTW-1:0]        ld_count;
  logic [EXCW-1:0]        ld_nexc;
  logic [MAXEXC*CNTW-1:0] ld_exc;

  assign head_exc = mir_pkg::must_record(head_crossed, head_conflict, opt_mode);

  mir_track_table #(.DEPTH(DEPTH), .LINEW(LINEW)) u_table (
    .clk, .rst_n, .perf_valid, .perf_idx(perf_seq), .perf_line,
    .snoop_valid, .snoop_line, .close_iv, .head_idx, .clr(cnt_fire),
    .head_perf, .head_crossed, .head_conflict
  );

  mir_interval_acc #(.DEPTH(DEPTH), .CNTW(CNTW), .MAXEXC(MAXEXC)) u_acc (
    .clk, .rst_n, .cnt_valid, .head_perf, .head_exc, .snoop_valid, .log_free,
    .cnt_ready, .cnt_fire, .close_iv, .log_load, .head_idx,
    .ld_count, .ld_nexc, .ld_exc
  );

  mir_log_reg #(.CNTW(CNTW), .MAXEXC(MAXEXC)) u_log (
    .clk, .rst_n, .load(log_load), .in_count(ld_count), .in_nexc(ld_nexc),
    .in_exc(ld_exc), .log_ready, .log_valid, .log_free,
    .log_count, .log_nexc, .log_exc
  );

  // R7: an entry never lists more exceptions than accesses
  a_r7_nexc_le_count: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> (32'(log_nexc) <= 32'(log_count)));
  // R1: nothing is countable in the cycle after reset release
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!log_valid && !cnt_ready));

endmodule

// File: tb/mem_interval_recorder_bench.sv
module mem_interval_recorder_bench;
  localparam int DEPTH = 8, LINEW = 8, CNTW = 3, MAXEXC = 4;
  localparam int IDXW = $clog2(DEPTH), EXCW = $clog2(MAXEXC + 1);

  logic clk = 0, rst_n = 0, opt_mode = 0;
  logic perf_valid = 0, cnt_valid = 0, snoop_valid = 0, log_ready = 0;
  logic [IDXW-1:0] perf_seq = '0;
  logic [LINEW-1:0] perf_line = '0, snoop_line = '0;
  logic cnt_ready, log_valid;
  logic [CNTW-1:0] log_count;
  logic [EXCW-1:0] log_nexc;
  logic [MAXEXC*CNTW-1:0] log_exc;

  int total = 0, bad = 0, sq = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mem_interval_recorder #(.DEPTH(DEPTH), .LINEW(LINEW), .CNTW(CNTW), .MAXEXC(MAXEXC))
    u_mem_interval_recorder (.*);

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_perf(int seq, int line);
    perf_valid = 1; perf_seq = IDXW'(seq % DEPTH); perf_line = LINEW'(line);
    tick(); perf_valid = 0;
  endtask

  task automatic do_count(string req);
    cnt_valid = 1;
    check(req, "cnt_ready", int'(cnt_ready), 1);
    tick(); cnt_valid = 0;
  endtask

  task automatic do_snoop(int line);
    snoop_valid = 1; snoop_line = LINEW'(line);
    tick(); snoop_valid = 0;
  endtask

  task automatic expect_entry(string req, int c, int n, int e0, int e1, int e2, int e3);
    check(req, "log_valid", int'(log_valid), 1);
    check(req, "log_count", int'(log_count), c);
    check(req, "log_nexc", int'(log_nexc), n);
    check(req, "exc0", int'(log_exc[0*CNTW +: CNTW]), e0);
    check(req, "exc1", int'(log_exc[1*CNTW +: CNTW]), e1);
    check(req, "exc2", int'(log_exc[2*CNTW +: CNTW]), e2);
    check(req, "exc3", int'(log_exc[3*CNTW +: CNTW]), e3);
    log_ready = 1; tick(); log_ready = 0;
    check(req, "log_valid after take", int'(log_valid), 0);
  endtask

  task automatic t_reset();
    check("R1", "log_valid", int'(log_valid), 0);
    check("R1", "cnt_ready", int'(cnt_ready), 0);
  endtask

  // R2 holdback, R3 out-of-order performs within one interval
  task automatic t_in_interval();
    opt_mode = 0;
    cnt_valid = 1; tick();
    check("R2", "cnt_ready before perform", int'(cnt_ready), 0);
    do_perf(sq, 8'h10);
    check("R2", "cnt_ready after perform", int'(cnt_ready), 1);
    tick(); cnt_valid = 0; sq++;
    do_perf(sq + 1, 8'h12);
    do_perf(sq, 8'h11);
    do_count("R3"); do_count("R3"); sq += 2;
    do_snoop(8'h55);
    expect_entry("R3", 3, 0, 0, 0, 0, 0);
  endtask

  // R4 empty interval and count in the snoop cycle
  task automatic t_close();
    do_snoop(8'h56);
    check("R4", "empty interval entry", int'(log_valid), 0);
    do_perf(sq, 8'h20);
    cnt_valid = 1; snoop_valid = 1; snoop_line = 8'h57;
    check("R4", "cnt_ready", int'(cnt_ready), 1);
    tick(); cnt_valid = 0; snoop_valid = 0; sq++;
    expect_entry("R4", 1, 0, 0, 0, 0, 0);
  endtask

  // R5, R7 base mode exception offset
  task automatic t_base();
    opt_mode = 0;
    do_perf(sq, 8'h30); do_perf(sq + 2, 8'h32);
    do_count("R5"); do_snoop(8'h99);
    expect_entry("R5", 1, 0, 0, 0, 0, 0);
    do_perf(sq + 1, 8'h31);
    do_count("R5"); do_count("R5"); sq += 3;
    do_snoop(8'h98);
    expect_entry("R7", 2, 1, 1, 0, 0, 0);
  endtask

  // R6 optimized mode: only a matching snoop forces an exception
  task automatic t_opt();
    opt_mode = 1;
    do_perf(sq, 8'h40); do_perf(sq + 1, 8'h41); do_perf(sq + 2, 8'h42);
    do_count("R6"); do_snoop(8'h41);
    expect_entry("R6", 1, 0, 0, 0, 0, 0);
    do_count("R6"); do_count("R6"); sq += 3;
    do_snoop(8'h97);
    expect_entry("R6", 2, 1, 0, 0, 0, 0);
  endtask

  // R8 back-pressure
  task automatic t_backpressure();
    opt_mode = 1;
    do_perf(sq, 8'h50); do_count("R8"); sq++;
    do_snoop(8'h96);
    do_perf(sq, 8'h51);
    cnt_valid = 1; tick();
    check("R8", "cnt_ready stalled", int'(cnt_ready), 0);
    check("R8", "held count", int'(log_count), 1);
    do_snoop(8'h51);
    check("R8", "held valid", int'(log_valid), 1);
    check("R8", "held count after snoop", int'(log_count), 1);
    cnt_valid = 0;
    expect_entry("R8", 1, 0, 0, 0, 0, 0);
    do_count("R8"); sq++;
    do_snoop(8'h95);
    expect_entry("R8", 1, 1, 0, 0, 0, 0);
  endtask

  // R9 exception list full
  task automatic t_exc_full();
    opt_mode = 0;
    for (int i = 0; i < 5; i++) do_perf(sq + i, 8'h60 + i);
    do_snoop(8'h94);
    check("R9", "no entry for empty interval", int'(log_valid), 0);
    for (int i = 0; i < 4; i++) do_count("R9");
    cnt_valid = 1;
    check("R9", "cnt_ready when full", int'(cnt_ready), 0);
    tick(); cnt_valid = 0;
    expect_entry("R9", 4, 4, 0, 1, 2, 3);
    do_count("R9"); sq += 5;
    do_snoop(8'h93);
    expect_entry("R9", 1, 1, 0, 0, 0, 0);
  endtask

  // R10 count saturation
  task automatic t_saturate();
    opt_mode = 1;
    for (int i = 0; i < 7; i++) begin
      do_perf(sq, 8'h70 + i); do_count("R10"); sq++;
    end
    do_perf(sq, 8'h7f);
    cnt_valid = 1;
    check("R10", "cnt_ready at max", int'(cnt_ready), 0);
    tick(); cnt_valid = 0;
    expect_entry("R10", 7, 0, 0, 0, 0, 0);
    do_count("R10"); sq++;
    do_snoop(8'h92);
    expect_entry("R10", 1, 0, 0, 0, 0, 0);
  endtask

  // R11 perform coinciding with a snoop to its own line
  task automatic t_same_cycle();
    opt_mode = 1;
    perf_valid = 1; perf_seq = IDXW'(sq % DEPTH); perf_line = 8'h80;
    snoop_valid = 1; snoop_line = 8'h80;
    tick(); perf_valid = 0; snoop_valid = 0;
    check("R11", "no entry", int'(log_valid), 0);
    do_count("R11"); sq++;
    do_snoop(8'h91);
    expect_entry("R11", 1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_in_interval();
    t_close();
    t_base();
    t_opt();
    t_backpressure();
    t_exc_full();
    t_saturate();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule